// File: doc/BRIEF.md
# Load-Locked Reservation Monitor

This block tracks one atomic reservation per hardware context so that a group of contexts can use load-locked / store-conditional pairs. Each context has its own request port carrying an operation code, a physical address and an uncacheable attribute. A load-locked records the address granule and arms that context's reservation. A store-conditional is checked against the issuing context's reservation. The block answers with a result code and a flag that says whether the memory write may go ahead.

Every store that is allowed to write is snooped against all reservations. Any reservation in the same 16-byte granule is dropped, including the issuer's own. Each context also keeps a saturating count of back-to-back store-conditional failures and raises a one-cycle warning every time a fixed number of consecutive failures is reached.

Stores and store-conditionals share a single commit path that serves one request per cycle, lowest context first. Load-locked requests bypass that path and are taken every cycle from every context. Memory access, translation and caching stay outside the block.

Top module: `resv_monitor`

## Requirements
- R1: A port with `req_valid` high and op code 2'b01 (load-locked) is always accepted (`req_ready` high). It records its address granule (address bits above GRAN_BITS) and arms that context's reservation at the next clock edge.
- R2: Granules are compared on the address with its low GRAN_BITS (default 4) bits dropped, so any two addresses inside one 16-byte granule match.
- R3: A cacheable store-conditional (op 2'b10, `req_unc` low) succeeds only if the issuer's reservation is armed and its granule equals the store's granule. On success it responds with result 1 and `rsp_write` high.
- R4: A cacheable store-conditional that does not succeed responds with result 0 and `rsp_write` low, and it disarms the issuer's reservation.
- R5: An uncacheable store-conditional skips the reservation check. It responds with result 2 and `rsp_write` high, and it resets the issuer's failure count to 0.
- R6: `fail_cnt` of a context returns to 0 on a successful store-conditional and increments on a failed one. It saturates at 2^FAIL_W-1.
- R7: `fail_warn` of a context pulses high for one cycle, together with the response, whenever that context's run of consecutive failures reaches a nonzero multiple of WARN_PERIOD. The pulse keeps coming after the count has saturated.
- R8: A plain store (op 2'b11) responds with result 0 and `rsp_write` high. Every committed write (plain store, successful or uncacheable store-conditional) disarms every context whose recorded granule equals the written granule, the issuer included.
- R9: Among ports holding a valid store or store-conditional, only the lowest index is served in a cycle. `req_ready` of a port is low exactly when it does not carry op 2'b01 and a lower-indexed port holds a valid store or store-conditional.
- R10: After reset no reservation is armed, all failure counts are 0 and `rsp_valid` and `fail_warn` are low.
- R11: When a load-locked and a matching committed write from another context are taken in the same cycle, the load-locked's reservation ends armed.
- R12: A valid request with op code 2'b00 is ignored: it produces no response and does not change any reservation.
- R13: A response appears on `rsp_*` one clock after the request is accepted. `rsp_ctx` gives the served context and `rsp_sc` is high for a store-conditional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_CTX | Request present, one bit per context |
| req_op | input | 2*N_CTX | Op code per context: 00 none, 01 load-locked, 10 store-conditional, 11 store |
| req_addr | input | ADDR_W*N_CTX | Physical address per context |
| req_unc | input | N_CTX | Uncacheable attribute per context |
| req_ready | output | N_CTX | Request accepted this cycle |
| rsp_valid | output | 1 | Registered response for a served store or store-conditional |
| rsp_ctx | output | CTX_W | Context index of the response |
| rsp_sc | output | 1 | Response belongs to a store-conditional |
| rsp_result | output | 2 | 0 fail or plain store, 1 success, 2 uncacheable store-conditional |
| rsp_write | output | 1 | The memory write may proceed |
| fail_warn | output | N_CTX | One-cycle warning per context |
| fail_cnt | output | FAIL_W*N_CTX | Saturating consecutive-failure count per context |

## Verification
The collision that matters is a load-locked arming a reservation while, in the same cycle, a committed write from another context invalidates that same granule. The same applies to a failed store-conditional disarming the issuer while a snoop hits other contexts. The bench forces these directly: it issues a load-locked and a matching store on different ports in one cycle, and arms two contexts before a store clears both. The random phase draws addresses from three granules only, so such overlaps recur constantly. A bench model applies the invalidation before the new reservation, and the following store-conditional results judge whether the design did the same.

// File: rtl/resv_pkg.sv
package resv_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'b00,
      OP_LL   = 2'b01,
      OP_SC   = 2'b10,
      OP_ST   = 2'b11
   } resv_op_e;

   localparam logic [1:0] RES_FAIL   = 2'd0;
   localparam logic [1:0] RES_PASS   = 2'd1;
   localparam logic [1:0] RES_UNCACH = 2'd2;

   function automatic logic op_writes(input resv_op_e op);
      return (op == OP_SC) || (op == OP_ST);
   endfunction

endpackage

// File: rtl/resv_arbiter.sv
module resv_arbiter #(
   parameter int N_CTX = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_CTX-1:0] want,
   output logic [N_CTX-1:0] grant,
   output logic [N_CTX-1:0] blocked
);

   generate
      if (N_CTX == 1) begin : g_single
         assign grant   = want;
         assign blocked = 1'b0;
      end else begin : g_chain
         always_comb begin
            logic ahead;
            ahead = 1'b0;
            for (int k = 0; k < N_CTX; k++) begin
               blocked[k] = ahead;
               grant[k]   = want[k] && !ahead;
               ahead      = ahead || want[k];
            end
         end
      end
   endgenerate

   assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_grant_wanted_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~want) == '0);

   assert_served_when_any_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (want != '0) |-> (grant != '0));

endmodule

// File: rtl/resv_slot.sv
module resv_slot #(
   parameter int GRAN_W      = 36,
   parameter int FAIL_W      = 17,
   parameter int WARN_PERIOD = 100000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ll_set,
   input  logic [GRAN_W-1:0] ll_gran,
   input  logic              snoop_vld,
   input  logic [GRAN_W-1:0] snoop_gran,
   input  logic              sc_fail,
   input  logic              sc_pass,
   output logic              resv_vld,
   output logic [GRAN_W-1:0] resv_gran,
   output logic [FAIL_W-1:0] fail_cnt,
   output logic              warn
);

   localparam int                PH_W     = $clog2(WARN_PERIOD);
   localparam logic [FAIL_W-1:0] CNT_MAX  = '1;
   localparam logic [PH_W-1:0]   PH_LAST  = PH_W'(WARN_PERIOD - 1);

   logic [PH_W-1:0] phase;
   logic            snoop_hit;

   assign snoop_hit = snoop_vld && (snoop_gran == resv_gran);

   // Reservation: a new load-locked wins over any clearing event that
   // lands in the same cycle.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resv_vld  <= 1'b0;
         resv_gran <= '0;
      end else if (ll_set) begin
         resv_vld  <= 1'b1;
         resv_gran <= ll_gran;
      end else if (sc_fail || snoop_hit) begin
         resv_vld  <= 1'b0;
      end
   end

   // Failure run: saturating count plus a wrap counter for the warning.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fail_cnt <= '0;
         phase    <= '0;
         warn     <= 1'b0;
      end else begin
         warn <= 1'b0;
         if (sc_pass) begin
            fail_cnt <= '0;
            phase    <= '0;
         end else if (sc_fail) begin
            if (fail_cnt != CNT_MAX) begin
               fail_cnt <= fail_cnt + 1'b1;
            end
            if (phase == PH_LAST) begin
               phase <= '0;
               warn  <= 1'b1;
            end else begin
               phase <= phase + 1'b1;
            end
         end
      end
   end

   assert_ll_arms_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ll_set |=> (resv_vld && resv_gran == $past(ll_gran)));

   assert_fail_disarms_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_fail && !ll_set) |=> !resv_vld);

   assert_snoop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_hit && !ll_set) |=> !resv_vld);

   assert_pass_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sc_pass |=> (fail_cnt == '0));

   assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_fail && fail_cnt == CNT_MAX) |=> (fail_cnt == CNT_MAX));

   assert_warn_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      warn |=> !warn);

   assert_warn_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      warn |-> $past(sc_fail));

endmodule

// File: rtl/resv_judge.sv
module resv_judge
   import resv_pkg::*;
#(
   parameter int N_CTX  = 4,
   parameter int GRAN_W = 36,
   parameter int CTX_W  = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_CTX-1:0]              grant,
   input  logic [N_CTX-1:0][1:0]         op_v,
   input  logic [N_CTX-1:0][GRAN_W-1:0]  gran_v,
   input  logic [N_CTX-1:0]              unc_v,
   input  logic [N_CTX-1:0]              slot_vld,
   input  logic [N_CTX-1:0][GRAN_W-1:0]  slot_gran,
   output logic                          served,
   output logic [CTX_W-1:0]              srv_ctx,
   output logic                          srv_sc,
   output logic [1:0]                    srv_result,
   output logic                          commit,
   output logic [GRAN_W-1:0]             commit_gran,
   output logic [N_CTX-1:0]              sc_fail,
   output logic [N_CTX-1:0]              sc_pass
);

   resv_op_e          sel_op;
   logic              sel_unc;
   logic              own_vld;
   logic [GRAN_W-1:0] own_gran;
   logic              pass;

   always_comb begin
      served      = 1'b0;
      srv_ctx     = '0;
      sel_op      = OP_NONE;
      sel_unc     = 1'b0;
      commit_gran = '0;
      own_vld     = 1'b0;
      own_gran    = '0;
      for (int k = 0; k < N_CTX; k++) begin
         if (grant[k]) begin
            served      = 1'b1;
            srv_ctx     = CTX_W'(k);
            sel_op      = resv_op_e'(op_v[k]);
            sel_unc     = unc_v[k];
            commit_gran = gran_v[k];
            own_vld     = slot_vld[k];
            own_gran    = slot_gran[k];
         end
      end
   end

   always_comb begin
      srv_sc = served && (sel_op == OP_SC);
      pass   = srv_sc && (sel_unc || (own_vld && (own_gran == commit_gran)));
      commit = served && ((sel_op == OP_ST) || pass);
      if (!srv_sc)      srv_result = RES_FAIL;
      else if (sel_unc) srv_result = RES_UNCACH;
      else if (pass)    srv_result = RES_PASS;
      else              srv_result = RES_FAIL;
      sc_pass = pass ? grant : '0;
      sc_fail = (srv_sc && !pass) ? grant : '0;
   end

   assert_pass_fail_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_pass & sc_fail) == '0);

   assert_fail_no_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_fail != '0) |-> !commit);

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
   import resv_pkg::*;
#(
   parameter int N_CTX       = 4,
   parameter int ADDR_W      = 40,
   parameter int GRAN_BITS   = 4,
   parameter int FAIL_W      = 17,
   parameter int WARN_PERIOD = 100000,
   localparam int CTX_W      = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_CTX-1:0]           req_valid,
   input  logic [2*N_CTX-1:0]         req_op,
   input  logic [ADDR_W*N_CTX-1:0]    req_addr,
   input  logic [N_CTX-1:0]           req_unc,
   output logic [N_CTX-1:0]           req_ready,
   output logic                       rsp_valid,
   output logic [CTX_W-1:0]           rsp_ctx,
   output logic                       rsp_sc,
   output logic [1:0]                 rsp_result,
   output logic                       rsp_write,
   output logic [N_CTX-1:0]           fail_warn,
   output logic [FAIL_W*N_CTX-1:0]    fail_cnt
);

   localparam int GRAN_W = ADDR_W - GRAN_BITS;

   generate
      if (N_CTX < 1)              begin : g_bad_ctx  $error("N_CTX must be at least 1");        end
      if (GRAN_BITS >= ADDR_W)    begin : g_bad_gran $error("GRAN_BITS must be below ADDR_W");   end
      if (WARN_PERIOD < 2)        begin : g_bad_warn $error("WARN_PERIOD must be at least 2");   end
      if (FAIL_W < 1)             begin : g_bad_fail $error("FAIL_W must be at least 1");        end
   endgenerate

   logic [N_CTX-1:0][1:0]        op_v;
   logic [N_CTX-1:0][GRAN_W-1:0] gran_v;
   logic [N_CTX-1:0]             want, ll_v, grant, blocked;
   logic [N_CTX-1:0]             slot_vld, sc_fail, sc_pass;
   logic [N_CTX-1:0][GRAN_W-1:0] slot_gran;

   logic              served, srv_sc, commit;
   logic [CTX_W-1:0]  srv_ctx;
   logic [1:0]        srv_result;
   logic [GRAN_W-1:0] commit_gran;

   generate
      for (genvar k = 0; k < N_CTX; k++) begin : g_port
         assign op_v[k]      = req_op[2*k +: 2];
         assign gran_v[k]    = req_addr[k*ADDR_W + GRAN_BITS +: GRAN_W];
         assign want[k]      = req_valid[k] && op_writes(resv_op_e'(op_v[k]));
         assign ll_v[k]      = req_valid[k] && (op_v[k] == OP_LL);
         assign req_ready[k] = (op_v[k] == OP_LL) || !blocked[k];
      end
   endgenerate

   resv_arbiter #(.N_CTX(N_CTX)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .want    (want),
      .grant   (grant),
      .blocked (blocked)
   );

   resv_judge #(.N_CTX(N_CTX), .GRAN_W(GRAN_W), .CTX_W(CTX_W)) u_judge (
      .clk         (clk),
      .rst_n       (rst_n),
      .grant       (grant),
      .op_v        (op_v),
      .gran_v      (gran_v),
      .unc_v       (req_unc),
      .slot_vld    (slot_vld),
      .slot_gran   (slot_gran),
      .served      (served),
      .srv_ctx     (srv_ctx),
      .srv_sc      (srv_sc),
      .srv_result  (srv_result),
      .commit      (commit),
      .commit_gran (commit_gran),
      .sc_fail     (sc_fail),
      .sc_pass     (sc_pass)
   );

   generate
      for (genvar k = 0; k < N_CTX; k++) begin : g_slot
         logic [FAIL_W-1:0] cnt_k;
         resv_slot #(
            .GRAN_W      (GRAN_W),
            .FAIL_W      (FAIL_W),
            .WARN_PERIOD (WARN_PERIOD)
         ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .ll_set     (ll_v[k]),
            .ll_gran    (gran_v[k]),
            .snoop_vld  (commit),
            .snoop_gran (commit_gran),
            .sc_fail    (sc_fail[k]),
            .sc_pass    (sc_pass[k]),
            .resv_vld   (slot_vld[k]),
            .resv_gran  (slot_gran[k]),
            .fail_cnt   (cnt_k),
            .warn       (fail_warn[k])
         );
         assign fail_cnt[k*FAIL_W +: FAIL_W] = cnt_k;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_ctx    <= '0;
         rsp_sc     <= 1'b0;
         rsp_result <= RES_FAIL;
         rsp_write  <= 1'b0;
      end else begin
         rsp_valid  <= served;
         rsp_ctx    <= srv_ctx;
         rsp_sc     <= srv_sc;
         rsp_result <= srv_result;
         rsp_write  <= commit;
      end
   end

   assert_addr_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid != '0) |-> !$isunknown(req_addr));

   assert_fail_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_sc && rsp_result == RES_FAIL) |-> !rsp_write);

   assert_uncached_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_result == RES_UNCACH) |-> (rsp_write && rsp_sc));

   assert_store_writes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_sc) |-> (rsp_write && rsp_result == RES_FAIL));

   assert_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !rsp_write);

   assert_rsp_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $past(want != '0) |-> rsp_valid);

   assert_ll_always_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ll_v & ~req_ready) == '0);

   assert_warn_with_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_warn != '0) |-> (rsp_valid && rsp_sc && rsp_result == RES_FAIL));

endmodule

// File: tb/sim_resv_monitor.sv
module sim_resv_monitor;

   localparam int N     = 4;
   localparam int AW    = 16;
   localparam int GB    = 4;
   localparam int FW    = 4;
   localparam int WP    = 6;
   localparam int CW    = 2;
   localparam int CMAX  = (1 << FW) - 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    req_valid = '0;
   logic [2*N-1:0]  req_op = '0;
   logic [AW*N-1:0] req_addr = '0;
   logic [N-1:0]    req_unc = '0;
   logic [N-1:0]    req_ready;
   logic            rsp_valid;
   logic [CW-1:0]   rsp_ctx;
   logic            rsp_sc;
   logic [1:0]      rsp_result;
   logic            rsp_write;
   logic [N-1:0]    fail_warn;
   logic [FW*N-1:0] fail_cnt;

   always #4 clk = ~clk;

   resv_monitor #(
      .N_CTX(N), .ADDR_W(AW), .GRAN_BITS(GB), .FAIL_W(FW), .WARN_PERIOD(WP)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_unc(req_unc), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_ctx(rsp_ctx), .rsp_sc(rsp_sc),
      .rsp_result(rsp_result), .rsp_write(rsp_write),
      .fail_warn(fail_warn), .fail_cnt(fail_cnt)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // stimulus for the next step
   bit       tv [N];
   bit [1:0] top [N];
   int       ta [N];
   bit       tu [N];

   // reference state
   bit mflag [N];
   int mgran [N];
   int consec [N];
   string cur = "";

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, cur, act, exp);
      end
   endtask

   function automatic int cnt_of(input int c);
      return (c > CMAX) ? CMAX : c;
   endfunction

   function automatic bit [1:0] op_code(input string s);
      if (s == "LL") return 2'b01;
      if (s == "SC") return 2'b10;
      if (s == "ST") return 2'b11;
      return 2'b00;
   endfunction

   task automatic idle_all();
      for (int k = 0; k < N; k++) begin
         tv[k] = 0; top[k] = 2'b00; ta[k] = 0; tu[k] = 0;
      end
   endtask

   task automatic put(input int k, input string op, input int addr, input bit unc);
      tv[k] = 1; top[k] = op_code(op); ta[k] = addr; tu[k] = unc;
   endtask

   task automatic step();
      int g;
      bit lower;
      bit e_rv, e_sc, e_wr, commit;
      int e_ctx, e_res, gr;
      bit [N-1:0] e_warn;
      string kind;
      for (int k = 0; k < N; k++) begin
         req_valid[k]            = tv[k];
         req_op[2*k +: 2]        = top[k];
         req_addr[AW*k +: AW]    = ta[k][AW-1:0];
         req_unc[k]              = tu[k];
      end
      #1;
      g = -1; lower = 0;
      for (int k = 0; k < N; k++) begin
         chk("R9 ready", req_ready[k], (top[k] == 2'b01) ? 1 : !lower);
         if (tv[k] && top[k][1]) begin
            if (!lower) g = k;
            lower = 1;
         end
      end
      e_warn = '0; e_rv = (g >= 0); e_sc = 0; e_wr = 0; e_ctx = 0; e_res = 0;
      commit = 0; kind = "R13";
      if (g >= 0) begin
         gr    = ta[g] >> GB;
         e_ctx = g;
         e_sc  = (top[g] == 2'b10);
         if (e_sc) begin
            if (tu[g]) begin
               e_res = 2; e_wr = 1; commit = 1; consec[g] = 0; kind = "R5";
            end else if (mflag[g] && mgran[g] == gr) begin
               e_res = 1; e_wr = 1; commit = 1; consec[g] = 0; kind = "R3";
            end else begin
               e_res = 0; e_wr = 0; mflag[g] = 0; consec[g]++; kind = "R4";
               if (consec[g] % WP == 0) e_warn[g] = 1;
            end
         end else begin
            e_res = 0; e_wr = 1; commit = 1; kind = "R8";
         end
         if (commit)
            for (int j = 0; j < N; j++)
               if (mgran[j] == gr) mflag[j] = 0;
      end
      for (int k = 0; k < N; k++)
         if (tv[k] && top[k] == 2'b01) begin
            mflag[k] = 1; mgran[k] = ta[k] >> GB;
         end
      @(posedge clk);
      @(negedge clk);
      chk("R13 rsp_valid", rsp_valid, e_rv);
      if (e_rv) begin
         chk("R13 rsp_ctx", rsp_ctx, e_ctx);
         chk("R13 rsp_sc", rsp_sc, e_sc);
         chk({kind, " rsp_result"}, rsp_result, e_res);
         chk({kind, " rsp_write"}, rsp_write, e_wr);
      end
      chk("R7 fail_warn", fail_warn, e_warn);
      for (int k = 0; k < N; k++)
         chk("R6 fail_cnt", fail_cnt[FW*k +: FW], cnt_of(consec[k]));
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      void'($urandom(32'h5eed1234));
      for (int k = 0; k < N; k++) begin
         mflag[k] = 0; mgran[k] = 0; consec[k] = 0;
      end
      idle_all();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R10: reset state
      cur = "R10 reset";
      chk("R10 rsp_valid", rsp_valid, 0);
      chk("R10 fail_warn", fail_warn, 0);
      chk("R10 fail_cnt", fail_cnt, 0);
      idle_all(); step();
      idle_all(); put(0, "SC", 'h000, 0); step();   // no reservation after reset

      // R1, R2: granule match ignores low 4 bits
      cur = "R1 R2 granule";
      idle_all(); put(1, "LL", 'h123, 0); step();
      idle_all(); put(1, "SC", 'h12F, 0); step();
      idle_all(); put(1, "LL", 'h123, 0); step();
      idle_all(); put(1, "SC", 'h130, 0); step();

      // R11: load-locked and matching store in one cycle
      cur = "R11 same-cycle";
      idle_all(); put(2, "LL", 'h200, 0); put(0, "ST", 'h205, 0); step();
      idle_all(); put(2, "SC", 'h20A, 0); step();

      // R8: store clears other contexts and the issuer
      cur = "R8 snoop";
      idle_all(); put(1, "LL", 'h300, 0); put(3, "LL", 'h301, 0); step();
      idle_all(); put(2, "ST", 'h30F, 0); step();
      idle_all(); put(1, "SC", 'h300, 0); step();
      idle_all(); put(3, "SC", 'h300, 0); step();
      idle_all(); put(0, "LL", 'h400, 0); step();
      idle_all(); put(0, "SC", 'h400, 1); step();
      idle_all(); put(0, "SC", 'h400, 0); step();

      // R9: four writers at once
      cur = "R9 priority";
      idle_all();
      for (int k = 0; k < N; k++) put(k, "SC", 'h600 + k, 0);
      step();
      idle_all(); put(2, "ST", 'h700, 0); put(3, "SC", 'h700, 0); put(1, "LL", 'h700, 0); step();

      // R6, R7: long failure run, saturation, then uncacheable reset (R5)
      cur = "R6 R7 run";
      for (int i = 0; i < 20; i++) begin
         idle_all(); put(2, "SC", 'h800, 0); step();
      end
      idle_all(); put(2, "SC", 'h800, 1); step();
      idle_all(); put(2, "SC", 'h800, 0); step();

      // R12: op code 00 is ignored
      cur = "R12 nop";
      idle_all(); put(0, "LL", 'h500, 0); step();
      idle_all(); put(0, "NOP", 'h500, 0); put(1, "NOP", 'h500, 0); step();
      idle_all(); put(0, "SC", 'h500, 0); step();

      // random phase
      cur = "random";
      for (int n = 0; n < 3000; n++) begin
         idle_all();
         for (int k = 0; k < N; k++) begin
            int r;
            if ($urandom_range(1, 0) == 1) begin
               r = $urandom_range(9, 0);
               tv[k]  = 1;
               top[k] = (r < 3) ? 2'b01 : (r < 7) ? 2'b10 : (r < 9) ? 2'b11 : 2'b00;
               ta[k]  = ((16 + $urandom_range(2, 0)) << GB) | $urandom_range(15, 0);
               tu[k]  = ($urandom_range(7, 0) == 0);
            end
         end
         step();
      end

      summary();
   end

endmodule